// File: doc/BRIEF.md
# Fractional Fixed-Point Multiply-Accumulate with Guard Bits

This block is the arithmetic core of a signal-processing datapath. On every clock cycle it takes two signed fractional operands, forms their exact product, and either adds that product into a wide accumulator, loads it there in place of the old contents, clears the accumulator, or leaves it alone. The accumulator carries guard bits above the product width, so a long run of full-scale products can be summed without intermediate wrap-around.

A separate store path reduces the accumulator to an operand-width result whenever it is asked to. It first rounds under one of three selectable policies: chop, nearest with ties upward, or ties to even. It then clamps the rounded value into the representable fractional range. Each clamp raises a sticky overflow flag that stays set until the accumulator is cleared. The store result is registered and comes with a one-cycle valid pulse.

Operands use the format with one sign bit and DW-1 fraction bits, so the value range is -1 ≤ x < 1. With the default DW = 24 and GW = 8, the product is 48 bits and the accumulator is 56 bits.

Top module: `fxp_mac_guard`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `res` is 0, `res_vld` is 0 and `ovf_sticky` is 0. The accumulator is also 0, so a store issued straight after reset returns 0.
- R2: Operands are signed fractions with DW-1 fraction bits. The product is the two's-complement product shifted left by one bit, giving 2*DW-1 fraction bits. The single case of most-negative times most-negative yields the most positive product value, not a wrapped one.
- R3: The `op` encodings are as follows. Each takes effect at the clock edge at which it is presented, one operation per cycle.
  - 2'b00 holds the accumulator unchanged.
  - 2'b01 clears it to 0.
  - 2'b10 adds the product to it.
  - 2'b11 replaces it with the product.
- R4: The accumulator is 2*DW+GW bits wide. Any sum of up to 2^GW products is held exactly, whatever their signs.
- R5: When `store_en` is high at an edge, the store path uses the accumulator value from before that edge's update. `res` shows the reduced value after the edge, and `res_vld` is high for exactly that cycle. When `store_en` is low, `res` keeps its value and `res_vld` is 0.
- R6: `rnd_mode` 2'b00 (chop) discards the low 2*DW-1-(DW-1) = DW accumulator bits, which rounds toward minus infinity.
- R7: `rnd_mode` 2'b01 (nearest) rounds up when the discarded part is one half or more of one result LSB, and down otherwise.
- R8: `rnd_mode` 2'b10 (convergent) rounds up above one half and down below one half. At exactly one half it picks the result whose LSB is 0. The unused code 2'b11 behaves like chop.
- R9: Saturation follows rounding. A rounded value above 2^(DW-1)-1 LSBs gives 2^(DW-1)-1, and one below -2^(DW-1) gives -2^(DW-1). No result ever wraps.
- R10: `ovf_sticky` is set after any store that saturated. It is cleared only by reset or by a clear operation (`op` = 2'b01). When a clear and a saturating store fall in the same cycle, the flag is left set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 2 | Accumulator operation: hold, clear, add product, load product |
| rnd_mode | input | 2 | Rounding policy used by the store path |
| opa | input | DW | First signed fractional operand |
| opb | input | DW | Second signed fractional operand |
| store_en | input | 1 | Reduce the accumulator to a result at this edge |
| res | output | DW | Registered rounded and saturated result |
| res_vld | output | 1 | One-cycle pulse marking a new result |
| ovf_sticky | output | 1 | Set when a store saturated; cleared by a clear operation |

## Verification
There are two same-cycle collisions to cover.

The first is a store alongside an accumulator update. The bench runs every operand pair of a 6-bit configuration through a pipelined sweep in each rounding mode. At every edge it loads the next product and stores the previous one, so each result is judged against the value from before the update. Expected values come from integer arithmetic on the exact product.

The second is a clear that lands on the same edge as a saturating store. The bench first builds a large sum, then issues both together. It expects the flag to stay set and a following store to return zero.

// File: rtl/fxp_mac_pkg.sv
package fxp_mac_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'b00,
    OP_CLEAR = 2'b01,
    OP_ACC   = 2'b10,
    OP_LOAD  = 2'b11
  } mac_op_e;

  typedef enum logic [1:0] {
    RND_CHOP = 2'b00,
    RND_NEAR = 2'b01,
    RND_CONV = 2'b10,
    RND_RSVD = 2'b11
  } rnd_mode_e;

endpackage

// File: rtl/fxp_frac_mult.sv
module fxp_frac_mult #(
  parameter int DW = 24
) (
  input  logic signed [DW-1:0]   a,
  input  logic signed [DW-1:0]   b,
  output logic signed [2*DW-1:0] prod
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0] full;
  logic                 min_sq;

  always_comb begin
    full   = $signed({{DW{a[DW-1]}}, a}) * $signed({{DW{b[DW-1]}}, b});
    min_sq = (a == {1'b1, {(DW-1){1'b0}}}) && (b == {1'b1, {(DW-1){1'b0}}});
    // drop the duplicated sign bit; the only case that cannot fit is clamped
    if (min_sq) prod = {1'b0, {(PW-1){1'b1}}};
    else        prod = {full[PW-2:0], 1'b0};
  end

  always_comb begin
    if (a != '0 && b != '0)
      AST_PROD_SIGN: assert (prod[PW-1] == (a[DW-1] ^ b[DW-1])); // R2
  end

endmodule

// File: rtl/fxp_acc.sv
module fxp_acc
  import fxp_mac_pkg::*;
#(
  parameter int PW = 48,
  parameter int AW = 56
) (
  input  logic                 clk,
  input  logic                 rst,
  input  mac_op_e              op,
  input  logic signed [PW-1:0] prod,
  output logic signed [AW-1:0] acc
);
  localparam int GW = AW - PW;

  logic signed [AW-1:0] prod_ext;
  assign prod_ext = {{GW{prod[PW-1]}}, prod};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else begin
      unique case (op)
        OP_CLEAR: acc <= '0;
        OP_ACC:   acc <= acc + prod_ext;
        OP_LOAD:  acc <= prod_ext;
        default:  acc <= acc;
      endcase
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    op == OP_CLEAR |=> acc == '0); // R3
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    op == OP_HOLD |=> $stable(acc)); // R3

endmodule

// File: rtl/fxp_round_sat.sv
module fxp_round_sat
  import fxp_mac_pkg::*;
#(
  parameter int AW   = 56,
  parameter int DW   = 24,
  parameter int DROP = 24
) (
  input  logic signed [AW-1:0] acc,
  input  rnd_mode_e            mode,
  output logic [DW-1:0]        res,
  output logic                 sat
);
  localparam int KW = AW - DROP;

  logic signed [KW-1:0] kept;
  logic [DROP-1:0]      frac;
  logic                 inc;
  logic signed [KW:0]   sum;
  logic                 sat_hi;
  logic                 sat_lo;

  assign kept = acc[AW-1:DROP];
  assign frac = acc[DROP-1:0];

  always_comb begin
    unique case (mode)
      RND_NEAR: inc = frac[DROP-1];
      RND_CONV: inc = frac[DROP-1] & ((|frac[DROP-2:0]) | kept[0]);
      default:  inc = 1'b0;
    endcase
  end

  always_comb begin
    sum    = {kept[KW-1], kept} + {{KW{1'b0}}, inc};
    sat_hi = !sum[KW] && (|sum[KW-1:DW-1]);
    sat_lo = sum[KW] && !(&sum[KW-1:DW-1]);
    sat    = sat_hi | sat_lo;
    if (sat_hi)      res = {1'b0, {(DW-1){1'b1}}};
    else if (sat_lo) res = {1'b1, {(DW-1){1'b0}}};
    else             res = sum[DW-1:0];
  end

endmodule

// File: rtl/fxp_mac_guard.sv
module fxp_mac_guard
  import fxp_mac_pkg::*;
#(
  parameter int DW = 24,
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    op,
  input  logic [1:0]    rnd_mode,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic          store_en,
  output logic [DW-1:0] res,
  output logic          res_vld,
  output logic          ovf_sticky
);
  localparam int PW = 2 * DW;
  localparam int AW = PW + GW;

  mac_op_e              op_e;
  rnd_mode_e            rnd_e;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] acc;
  logic [DW-1:0]        rs_val;
  logic                 rs_sat;

  assign op_e  = mac_op_e'(op);
  assign rnd_e = rnd_mode_e'(rnd_mode);

  fxp_frac_mult #(.DW(DW)) u_mult (
    .a    (opa),
    .b    (opb),
    .prod (prod)
  );

  fxp_acc #(.PW(PW), .AW(AW)) u_acc (
    .clk  (clk),
    .rst  (rst),
    .op   (op_e),
    .prod (prod),
    .acc  (acc)
  );

  fxp_round_sat #(.AW(AW), .DW(DW), .DROP(PW - DW)) u_rs (
    .acc  (acc),
    .mode (rnd_e),
    .res  (rs_val),
    .sat  (rs_sat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res        <= '0;
      res_vld    <= 1'b0;
      ovf_sticky <= 1'b0;
    end else begin
      res_vld    <= store_en;
      if (store_en) res <= rs_val;
      ovf_sticky <= (ovf_sticky && op_e != OP_CLEAR) || (store_en && rs_sat);
    end
  end

  AST_VLD_ON_STORE: assert property (@(posedge clk) disable iff (rst)
    store_en |=> res_vld); // R5
  AST_VLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    !store_en |=> !res_vld); // R5
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
    !store_en |=> $stable(res)); // R5
  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst)
    ovf_sticky && op_e != OP_CLEAR |=> ovf_sticky); // R10

endmodule

// File: tb/fxp_mac_guard_bench.sv
`timescale 1ns/1ps
module fxp_mac_guard_bench;
  localparam int DW   = 6;
  localparam int GW   = 4;
  localparam int HALF = 1 << (DW - 1);
  localparam int LSB  = 1 << DW;
  localparam int NP   = 1 << (2 * DW);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    op = '0;
  logic [1:0]    rnd_mode = '0;
  logic [DW-1:0] opa = '0;
  logic [DW-1:0] opb = '0;
  logic          store_en = 1'b0;
  logic [DW-1:0] res;
  logic          res_vld;
  logic          ovf_sticky;

  int checks = 0;
  int errors = 0;
  int macc = 0;
  bit msticky = 1'b0;

  always #4 clk = ~clk;

  fxp_mac_guard #(.DW(DW), .GW(GW)) u_fxp_mac_guard (
    .clk        (clk),
    .rst        (rst),
    .op         (op),
    .rnd_mode   (rnd_mode),
    .opa        (opa),
    .opb        (opb),
    .store_en   (store_en),
    .res        (res),
    .res_vld    (res_vld),
    .ovf_sticky (ovf_sticky)
  );

  function automatic int prod_exp(int a, int b);
    if (a == -HALF && b == -HALF) return 2 * HALF * HALF - 1;
    return 2 * a * b;
  endfunction

  function automatic int rnd_exp(int v, int m, output bit s);
    int kept, frac, r;
    kept = v >>> DW;
    frac = v - kept * LSB;
    r = kept;
    if (m == 1 && frac >= HALF) r = kept + 1;
    if (m == 2 && (frac > HALF || (frac == HALF && (kept % 2) != 0))) r = kept + 1;
    s = 1'b0;
    if (r > HALF - 1) begin r = HALF - 1; s = 1'b1; end
    if (r < -HALF)    begin r = -HALF;    s = 1'b1; end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input int o, input int a, input int b, input bit st, input int m, input string tag);
    bit s;
    int er, ra;
    op = o[1:0]; opa = a[DW-1:0]; opb = b[DW-1:0];
    store_en = st; rnd_mode = m[1:0];
    er = 0; s = 1'b0;
    if (st) er = rnd_exp(macc, m, s);
    msticky = (msticky && o != 1) || (st && s);
    case (o)
      1: macc = 0;
      2: macc = macc + prod_exp(a, b);
      3: macc = prod_exp(a, b);
      default: ;
    endcase
    @(posedge clk); #1;
    chk(res_vld == st, tag, "res_vld", int'(res_vld), int'(st));
    if (st) begin
      ra = $signed(res);
      chk(ra == er, tag, "res", ra, er);
    end
    chk(ovf_sticky == msticky, tag, "ovf_sticky", int'(ovf_sticky), int'(msticky));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int ra;
    repeat (3) @(posedge clk);
    #1;
    ra = $signed(res);
    chk(ra == 0, "R1", "res in reset", ra, 0);
    chk(res_vld == 1'b0, "R1", "res_vld in reset", int'(res_vld), 0);
    rst = 1'b0;
    @(posedge clk); #1;
    chk(ovf_sticky == 1'b0, "R1", "ovf_sticky after reset", int'(ovf_sticky), 0);
    step(0, 0, 0, 1, 0, "R1");

    // R3: hold keeps a loaded product, clear zeroes it
    step(3, 10, -7, 0, 0, "R3");
    step(0, 31, 31, 0, 0, "R3");
    step(0, 0, 0, 1, 1, "R3");
    step(1, 0, 0, 0, 0, "R3");
    step(0, 5, 5, 1, 0, "R3");

    // R4 / R9 / R10: guard bits through overflow and back
    step(3, -HALF, -HALF, 0, 0, "R4");
    for (int k = 0; k < 7; k++) step(2, -HALF, -HALF, 0, 0, "R4");
    step(0, 0, 0, 1, 0, "R9 R10");
    for (int k = 0; k < 8; k++) step(2, -HALF, HALF - 1, 0, 0, "R4");
    step(0, 0, 0, 1, 0, "R4");

    // R10: clear colliding with a saturating store
    step(3, -HALF, -HALF, 0, 0, "R10");
    for (int k = 0; k < 3; k++) step(2, -HALF, -HALF, 0, 0, "R10");
    step(1, 0, 0, 1, 2, "R10");
    step(0, 0, 0, 1, 2, "R10");
    step(1, 0, 0, 0, 0, "R10");

    // R2 R5 R6 R7 R8 R9: exhaustive pipelined load+store sweep per mode
    for (int m = 0; m < 4; m++) begin
      string tg;
      case (m)
        0: tg = "R2 R5 R6 R9";
        1: tg = "R2 R5 R7 R9";
        default: tg = "R2 R5 R8 R9";
      endcase
      step(1, 0, 0, 0, m, tg);
      for (int i = 0; i <= NP; i++) begin
        int a, b;
        a = (i >> DW) - HALF;
        b = (i & (LSB - 1)) - HALF;
        step((i < NP) ? 3 : 0, a, b, i > 0, m, tg);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule